// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block collects level-sensitive interrupt lines in sets of eight and gives each set one output wire toward a parent interrupt controller. Every input line has its own enable bit. A group's output is high while at least one of its enabled lines is high. The output comes from a register, so it follows the inputs one clock later.

Software reaches the block through a plain write-strobe and address bus, and read data comes back combinationally. Four groups share one 32-bit register bank, each group in its own byte lane. Each bank holds:

- a register that sets enable bits,
- a register that clears enable bits,
- a reserved word,
- a masked status word.

Enables never take a full write. Software changes them by naming the bits to turn on or the bits to turn off, so two agents can change different lines without a read-modify-write race. The number of groups is a parameter. A last bank that is only partly filled behaves as if the missing lanes were not there.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset every enable bit is 0, every group output is 0, and every status word reads 0, whatever the inputs are doing.
- R2: A write to byte offset 0x0 of a bank (address bits [3:2] = 0) sets each enable bit whose data bit is 1. Data bits that are 0 leave their enable bits unchanged.
- R3: A write to byte offset 0x4 of a bank (address bits [3:2] = 1) clears each enable bit whose data bit is 1. Data bits that are 0 leave their enable bits unchanged.
- R4: A read of offset 0x0 or 0x4 returns the current 32 enable bits of the addressed bank. A read of offset 0x8 returns 0.
- R5: A read of offset 0xC returns, for each bit k of bank b, input line b*32+k ANDed with its enable bit.
- R6: The output of group g is high one clock after any enabled input in lines g*8 to g*8+7 is high. It stays high for as long as that holds, and falls one clock after it stops holding.
- R7: Group g sits in bank g/4, which starts at byte address (g/4)*0x10. Within that bank it uses bits [(g mod 4)*8 +: 8]. Address bits [1:0] are not decoded.
- R8: In the last bank, byte lanes that belong to no existing group read as 0 and cannot be enabled. Addresses of banks past the last one read 0, and writes to them change nothing.
- R9: Writes to offset 0x8 or 0xC leave every enable bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_GROUPS*8 | Level-sensitive interrupt lines, eight per group |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| group_irq | output | NUM_GROUPS | One registered interrupt output per group |

## Verification
The bench builds the block with NUM_GROUPS = 6 and ADDR_W = 8.

- Six groups make bank 0 full and leave bank 1 with only its lower two byte lanes populated. This puts the unpopulated-lane masking in reach.
- An 8-bit address leaves banks 2 through 15 unmapped, so writes to missing banks and reads from them are exercised.
- The stimulus table mixes set and clear writes that overlap and that carry zero data. It also includes writes aimed at the reserved and status offsets.

Directed tests then check the one-clock output latency and that an output holds while an input stays high.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LANE_W      = 8;
  localparam int LANES_PER_B = 4;
  localparam int WORD_W      = LANE_W * LANES_PER_B;

  typedef enum logic [1:0] {
    REG_SET  = 2'd0,
    REG_CLR  = 2'd1,
    REG_RSV  = 2'd2,
    REG_STAT = 2'd3
  } irqc_reg_e;

  // register index from the low nibble of a byte address
  function automatic irqc_reg_e reg_of(input logic [3:0] lo);
    return irqc_reg_e'(lo[3:2]);
  endfunction

  // lanes of a bank that belong to an existing group
  function automatic logic [WORD_W-1:0] lane_mask(input int bank, input int ngroups);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int l = 0; l < LANES_PER_B; l++)
      if (bank * LANES_PER_B + l < ngroups) m[l*LANE_W +: LANE_W] = {LANE_W{1'b1}};
    return m;
  endfunction
endpackage

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank
  import irqc_pkg::*;
#(
  parameter int NUM_GROUPS = 6,
  parameter int BANK       = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  irqc_reg_e         reg_sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] en_word
);
  localparam logic [WORD_W-1:0] VALID = lane_mask(BANK, NUM_GROUPS);

  logic do_set, do_clr;
  assign do_set = wr_hit && (reg_sel == REG_SET);
  assign do_clr = wr_hit && (reg_sel == REG_CLR);

  always_ff @(posedge clk) begin
    if (!rst_n)      en_word <= '0;
    else if (do_set) en_word <= en_word | (wdata & VALID);
    else if (do_clr) en_word <= en_word & ~wdata;
  end

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_set |=> ((en_word & $past(wdata & VALID)) == $past(wdata & VALID)));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> ((en_word & $past(wdata)) == '0));

  // R9
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_set || do_clr) |=> $stable(en_word));
endmodule

// File: rtl/irqc_group_out.sv
module irqc_group_out
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] lvl,
  input  logic [LANE_W-1:0] en,
  output logic              irq_q
);
  logic grp_hit;
  assign grp_hit = |(lvl & en);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= grp_hit;
  end

  // R6
  grp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !irq_q);
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
  import irqc_pkg::*;
#(
  parameter int NUM_GROUPS = 6,
  parameter int ADDR_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_GROUPS*8-1:0]    irq_in,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [31:0]                wdata,
  output logic [31:0]                rdata,
  output logic [NUM_GROUPS-1:0]      group_irq
);
  localparam int NUM_IN = NUM_GROUPS * LANE_W;
  localparam int BANKS  = (NUM_GROUPS + LANES_PER_B - 1) / LANES_PER_B;
  localparam int PAD_W  = BANKS * WORD_W;
  localparam int BANK_W = ADDR_W - 4;

  logic [PAD_W-1:0]  lvl_pad;
  logic [PAD_W-1:0]  en_pad;
  logic [BANK_W-1:0] bank_sel;
  irqc_reg_e         reg_sel;
  logic [BANKS-1:0]  wr_hit;

  assign lvl_pad  = PAD_W'(irq_in);
  assign bank_sel = addr[ADDR_W-1:4];
  assign reg_sel  = reg_of(addr[3:0]);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign wr_hit[b] = wr_en && (bank_sel == BANK_W'(b));
    irqc_enable_bank #(.NUM_GROUPS(NUM_GROUPS), .BANK(b)) u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_hit[b]),
      .reg_sel(reg_sel),
      .wdata  (wdata),
      .en_word(en_pad[b*WORD_W +: WORD_W])
    );
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    irqc_group_out u_grp (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (lvl_pad[g*LANE_W +: LANE_W]),
      .en   (en_pad[g*LANE_W +: LANE_W]),
      .irq_q(group_irq[g])
    );
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (bank_sel == BANK_W'(b)) begin
        case (reg_sel)
          REG_SET, REG_CLR: rdata = en_pad[b*WORD_W +: WORD_W];
          REG_STAT:         rdata = en_pad[b*WORD_W +: WORD_W] & lvl_pad[b*WORD_W +: WORD_W];
          default:          rdata = '0;
        endcase
      end
    end
  end

  // R4
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == REG_RSV) |-> (rdata == '0));

  // R8
  far_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(bank_sel) >= BANKS) |-> (rdata == '0));
endmodule

// File: tb/irq_group_combiner_bench.sv
module irq_group_combiner_bench;
  localparam int NG = 6;
  localparam int AW = 8;
  localparam int NI = NG * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] irq_in = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NG-1:0] group_irq;

  always #5 clk = ~clk;

  irq_group_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) u_irq_group_combiner (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .group_irq(group_irq)
  );

  typedef struct packed {
    logic          wr;
    logic [7:0]    a;
    logic [31:0]   d;
    logic [NI-1:0] lv;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h00, 32'h0000_00FF, 48'h0000_0000_0001}, // R2
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 48'h8000_0000_0000}, // R8 R7
    '{1'b1, 8'h04, 32'h0000_000F, 48'h0000_0000_00F0}, // R3
    '{1'b1, 8'h00, 32'h0F0F_0000, 48'h0000_0F00_0000}, // R2 R7
    '{1'b1, 8'h08, 32'hFFFF_FFFF, 48'h0000_0F00_0000}, // R9
    '{1'b1, 8'h0C, 32'hFFFF_FFFF, 48'h0000_0F00_0000}, // R9
    '{1'b1, 8'h20, 32'hFFFF_FFFF, 48'hFFFF_FFFF_FFFF}, // R8
    '{1'b1, 8'h14, 32'h0000_FF00, 48'hFFFF_0000_0000}, // R3
    '{1'b1, 8'h04, 32'h0000_0000, 48'h0000_00F0_0000}, // R3
    '{1'b1, 8'h00, 32'h0000_0000, 48'h0000_00F0_0000}, // R2
    '{1'b0, 8'h10, 32'hFFFF_FFFF, 48'hFFFF_FFFF_FFFF}, // R5
    '{1'b1, 8'h14, 32'hFFFF_FFFF, 48'hFFFF_FFFF_FFFF}  // R3 R6
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] men [NG];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    int bank = int'(a[7:4]);
    int r = int'(a[3:2]);
    for (int l = 0; l < 4; l++) begin
      int g = bank * 4 + l;
      if (g < NG) begin
        if (r == 0) men[g] = men[g] | d[l*8 +: 8];
        if (r == 1) men[g] = men[g] & ~d[l*8 +: 8];
      end
    end
  endtask

  function automatic logic [31:0] exp_en(input int bank);
    logic [31:0] w = '0;
    for (int l = 0; l < 4; l++)
      if (bank * 4 + l < NG) w[l*8 +: 8] = men[bank*4 + l];
    return w;
  endfunction

  function automatic logic [31:0] exp_stat(input int bank, input logic [NI-1:0] lv);
    logic [31:0] w = '0;
    for (int l = 0; l < 4; l++)
      if (bank * 4 + l < NG) w[l*8 +: 8] = men[bank*4 + l] & lv[(bank*4 + l)*8 +: 8];
    return w;
  endfunction

  function automatic logic [NG-1:0] exp_grp(input logic [NI-1:0] lv);
    logic [NG-1:0] o;
    for (int g = 0; g < NG; g++) o[g] = |(men[g] & lv[g*8 +: 8]);
    return o;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < NG; g++) men[g] = '0;
    irq_in = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 group_irq", 64'(group_irq), 64'(0));
    addr = 8'h00; #1 chk("R1 enable bank0", 64'(rdata), 64'(0));
    addr = 8'h0C; #1 chk("R1 status bank0", 64'(rdata), 64'(0));
    addr = 8'h1C; #1 chk("R1 status bank1", 64'(rdata), 64'(0));

    for (int i = 0; i < NV; i++) begin
      int bank;
      @(negedge clk);
      irq_in = VEC[i].lv; wr_en = VEC[i].wr; addr = VEC[i].a; wdata = VEC[i].d;
      @(posedge clk);
      if (VEC[i].wr) model_write(VEC[i].a, VEC[i].d);
      @(negedge clk);
      wr_en = 1'b0;
      bank = int'(VEC[i].a[7:4]);
      addr = {VEC[i].a[7:4], 4'h0}; #1
      chk($sformatf("R4 R2 R3 enables v%0d", i), 64'(rdata), 64'(exp_en(bank)));
      addr = {VEC[i].a[7:4], 4'h4}; #1
      chk($sformatf("R4 enables via clr offset v%0d", i), 64'(rdata), 64'(exp_en(bank)));
      addr = {VEC[i].a[7:4], 4'hC}; #1
      chk($sformatf("R5 status v%0d", i), 64'(rdata), 64'(exp_stat(bank, VEC[i].lv)));
      @(posedge clk);
      @(negedge clk);
      #1 chk($sformatf("R6 group_irq v%0d", i), 64'(group_irq), 64'(exp_grp(VEC[i].lv)));
    end

    // R4 reserved word reads zero with enables present
    wr(8'h00, 32'hFFFF_FFFF);
    addr = 8'h08; #1 chk("R4 reserved reads 0", 64'(rdata), 64'(0));
    addr = 8'h18; #1 chk("R4 reserved bank1 reads 0", 64'(rdata), 64'(0));
    // R8 far bank read
    addr = 8'hF0; #1 chk("R8 far bank read", 64'(rdata), 64'(0));
    // R7 address bits [1:0] not decoded
    addr = 8'h03; #1 chk("R7 low addr bits", 64'(rdata), 64'(32'hFFFF_FFFF));

    // R6 latency and hold on group 1, lane 3
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0000_0800);
    irq_in = '0;
    irq_in[11] = 1'b1;
    #1 chk("R6 not yet high", 64'(group_irq), 64'(0));
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      #1 chk("R6 held high", 64'(group_irq), 64'(6'b000010));
    end
    irq_in[11] = 1'b0;
    #1 chk("R6 one-cycle fall latency", 64'(group_irq), 64'(6'b000010));
    @(posedge clk);
    @(negedge clk);
    #1 chk("R6 fallen", 64'(group_irq), 64'(0));
    // R7 group 4 lives in bank1 lane0
    wr(8'h10, 32'h0000_0001);
    irq_in[32] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1 chk("R7 group4 mapping", 64'(group_irq), 64'(6'b010000));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule